// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital side of a four-input successive-approximation converter that talks over a synchronous serial port. All of its logic runs from the serial clock while the active-low select is asserted. While idle it watches the data input for a high start bit. It then collects the rest of an eight-bit command that chooses the input pairing, the resolution and the power behaviour. It opens a three-clock sampling window, holds the sample and resolves it one bit per clock. The result is shifted out on falling clock edges, most significant bit first.

In this digital model a parallel sample word stands in for the analog comparator. The word is captured at the hold instant, and a trial register resolves it bit by bit. The next command may start before the current result has finished streaming out, which gives back-to-back conversions with no idle gap.

Top module: `sar_serial_adc`

## Requirements
- R1: With select low and no command in progress, low data-input bits have no effect. The first high bit sampled on a rising edge is clock 1 of a command. Bits are then taken on the rising edges of clocks 2 to 8.
- R2: Command bits after the start bit are, in arrival order: a2, a1, a0, size, single, pw1, pw0. After clock 4, `mux_pos` = {a1, a2}. After clock 6, `neg_is_com` = single, and `mux_neg` = 0 when single is 1, otherwise `mux_pos` with its low bit inverted.
- R3: `sampling` is high from the rising edge of clock 5 to the rising edge of clock 8, which covers clocks 6, 7 and 8. `sample_in` is captured on the rising edge of clock 8.
- R4: `busy` goes high on the falling edge of clock 8 and low on the falling edge of clock 9. It is low at all other times.
- R5: In 12-bit mode, `dout` presents result bit 11 down to bit 0 on the falling edges of clocks 9 to 20. The result equals the captured sample. `dout` is 0 at every other falling edge.
- R6: With `res_sel` high and size = 1, a conversion is 8 bits. `dout` then carries sample[11:4], MSB first, on the falling edges of clocks 9 to 16. With `res_sel` low the size bit is ignored and the conversion is 12 bits.
- R7: While a conversion runs, a high data bit is not taken as a start bit before clock 16 (12-bit) or clock 12 (8-bit) of the previous command. From that clock on, a start bit is accepted while the previous result is still streaming.
- R8: `dout_en` and `busy_en` are high exactly while `cs_n` is low.
- R9: `cs_n` high at a rising edge discards any partial command and any running conversion. It clears `sampling`, and `busy` and `dout` are 0 at the next falling edge.
- R10: `powered` is low whenever `shdn_n` is low. Otherwise it is high during sampling and conversion. Between conversions it is high only if the last completed command had pw1,pw0 = 11. Codes 00, 01 and 10 power down between conversions.
- R11: A low `rst_n` at a clock edge clears all state. Outputs are 0, the power code becomes 00, and the mux outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; rising edge samples input, falling edge drives output |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and disables outputs |
| din | input | 1 | Serial command input |
| res_sel | input | 1 | Resolution pin; high lets the size bit pick 8 bits |
| shdn_n | input | 1 | Active-low forced shutdown |
| sample_in | input | 12 | Digital stand-in for the analog input, captured at hold |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Drive enable for `dout` |
| busy | output | 1 | Conversion-start indicator |
| busy_en | output | 1 | Drive enable for `busy` |
| sampling | output | 1 | Acquisition window active |
| mux_pos | output | 2 | Positive input channel index |
| mux_neg | output | 2 | Negative input channel index in differential mode |
| neg_is_com | output | 1 | Negative input taken from the common pin |
| powered | output | 1 | Converter analog section powered |

## Verification
The bench goes after the overlap window. A start bit arriving one clock too early must be ignored, while one arriving exactly on clock 16 or 12 must be taken. A wrong window either swallows a valid command or restarts the sequencer in the middle of streaming a result. An off-by-one in the bit counter would show up at the all-ones and the 0x001 sample values: the final bit would be missing or duplicated. Further scenarios cover an 8-bit request with the resolution pin low, a mid-command and a mid-conversion deselect, and the reserved power codes. Each targets a design that keeps stale state or powers up when it should not.

// File: rtl/sar_serial_pkg.sv
// Package: sar_serial_pkg
// Shared constants and the power-code type of the serial converter sequencer.
// Assumes a fixed eight-bit command with the start bit first.
package sar_serial_pkg;
    localparam int CMD_LEN    = 8;   // clocks per command
    localparam int POS_AT     = 4;   // clock after which +input is known
    localparam int ACQ_AT     = 5;   // clock at whose edge sampling opens
    localparam int NEG_AT     = 6;   // clock after which -input is known
    localparam int HIST_W     = 3;   // command history bits kept
    localparam int START_LEAD = 5;   // decisions left when a new start is allowed

    typedef enum logic [1:0] {
        PWR_AUTO  = 2'b00,
        PWR_RSV_A = 2'b01,
        PWR_RSV_B = 2'b10,
        PWR_ON    = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/sar_ctrl_rx.sv
// Module: sar_ctrl_rx
// Hunts for a start bit, counts the command clocks, decodes the input pairing,
// opens the sampling window and reports command completion.
// Assumes: rising-edge sampling of din; cs_n high forces the hunt state.
module sar_ctrl_rx
    import sar_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       din,
    input  logic       start_ok,
    output logic       cmd_done,
    output logic       short_req,
    output logic [1:0] pwr_code,
    output logic       acq,
    output logic [1:0] pos,
    output logic [1:0] neg,
    output logic       neg_com
);
    localparam int RX_CW = $clog2(CMD_LEN);
    localparam logic [RX_CW-1:0] LAST_IDX = RX_CW'(CMD_LEN - 1);

    logic [RX_CW-1:0]  rx_cnt_q;
    logic [HIST_W-1:0] hist_q;
    logic              hunting;

    assign hunting   = (rx_cnt_q == '0);
    assign cmd_done  = !cs_n && (rx_cnt_q == LAST_IDX);
    assign short_req = hist_q[2];
    assign pwr_code  = {hist_q[0], din};

    // Command clock counter and short bit history.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            rx_cnt_q <= '0;
            hist_q   <= '0;
        end else if (hunting) begin
            if (din && start_ok) begin
                rx_cnt_q <= RX_CW'(1);
                hist_q   <= HIST_W'(1);
            end
        end else begin
            hist_q   <= {hist_q[HIST_W-2:0], din};
            rx_cnt_q <= (rx_cnt_q == LAST_IDX) ? '0 : rx_cnt_q + 1'b1;
        end
    end

    // Sampling window: opens on clock 5, closes when the command completes.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            acq <= 1'b0;
        end else if (rx_cnt_q == RX_CW'(ACQ_AT - 1)) begin
            acq <= 1'b1;
        end else if (cmd_done) begin
            acq <= 1'b0;
        end
    end

    // Input pairing decode, kept across deselects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= '0;
            neg     <= '0;
            neg_com <= 1'b0;
        end else if (!cs_n) begin
            if (rx_cnt_q == RX_CW'(POS_AT - 1)) begin
                pos <= {hist_q[0], hist_q[1]};
            end
            if (rx_cnt_q == RX_CW'(NEG_AT - 1)) begin
                neg_com <= din;
                neg     <= din ? 2'b00 : (pos ^ 2'b01);
            end
        end
    end

    p_acq_holds_r3: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
        $rose(acq) |=> acq);

    p_acq_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !acq);

    p_early_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && din && !start_ok) |=> (rx_cnt_q == '0));
endmodule

// File: rtl/sar_conv_core.sv
// Module: sar_conv_core
// Captures the sample at hold and resolves it one bit per clock with a trial
// register, MSB first. Also says when a new start bit may be accepted.
// Assumes: SHORT_W >= START_LEAD and SHORT_W <= DATA_W.
module sar_conv_core
    import sar_serial_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              load,
    input  logic              res_sel,
    input  logic              short_req,
    input  logic [DATA_W-1:0] sample_in,
    output logic              active,
    output logic              hold,
    output logic              bit_valid,
    output logic              bit_out,
    output logic              start_ok
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     nbits_q;
    logic [DATA_W-1:0] samp_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] trial;
    logic              keep;

    assign trial     = acc_q | (TOP_ONE >> cnt_q);
    assign keep      = (trial <= samp_q);
    assign hold      = active && (cnt_q == '0);
    assign bit_valid = active && (cnt_q != '0);
    assign start_ok  = !active || ((int'(cnt_q) + START_LEAD) >= int'(nbits_q));

    // Hold capture and per-clock trial decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            nbits_q <= CW'(DATA_W);
            samp_q  <= '0;
            acc_q   <= '0;
            bit_out <= 1'b0;
        end else if (cs_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            active  <= 1'b1;
            cnt_q   <= '0;
            samp_q  <= sample_in;
            acc_q   <= '0;
            bit_out <= 1'b0;
            nbits_q <= (res_sel && short_req) ? CW'(SHORT_W) : CW'(DATA_W);
        end else if (active) begin
            if (cnt_q == nbits_q) begin
                active <= 1'b0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                acc_q   <= keep ? trial : acc_q;
                bit_out <= keep;
            end
        end
    end

    logic [DATA_W-1:0] kept_mask;
    assign kept_mask = {DATA_W{1'b1}} << (DATA_W - int'(nbits_q));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= nbits_q));

    p_result_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt_q == nbits_q) |-> (acc_q == (samp_q & kept_mask)));
endmodule

// File: rtl/sar_out_stage.sv
// Module: sar_out_stage
// Falling-edge registers for the busy flag and serial result bit.
// Assumes: inputs come from rising-edge logic and are stable at the falling edge.
module sar_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic hold,
    input  logic bit_valid,
    input  logic bit_in,
    output logic busy,
    output logic dout
);
    // Launch output values on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n || cs_n) begin
            busy <= 1'b0;
            dout <= 1'b0;
        end else begin
            busy <= hold;
            dout <= bit_valid && bit_in;
        end
    end

    p_busy_single_r4: assert property (@(negedge clk) disable iff (!rst_n)
        busy |=> !busy);

    p_quiet_when_busy_r5: assert property (@(negedge clk) disable iff (!rst_n)
        busy |-> !dout);
endmodule

// File: rtl/sar_serial_adc.sv
// Module: sar_serial_adc
// Top of the serial converter sequencer: command receiver, trial-register
// core and falling-edge output stage, plus the power-mode state.
// Assumes: clk is the serial clock; output enables drive external tristates.
module sar_serial_adc
    import sar_serial_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              din,
    input  logic              res_sel,
    input  logic              shdn_n,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dout,
    output logic              dout_en,
    output logic              busy,
    output logic              busy_en,
    output logic              sampling,
    output logic [1:0]        mux_pos,
    output logic [1:0]        mux_neg,
    output logic              neg_is_com,
    output logic              powered
);
    logic       cmd_done;
    logic       short_req;
    logic [1:0] pwr_code;
    logic       conv_active;
    logic       hold;
    logic       bit_valid;
    logic       bit_val;
    logic       start_ok;
    pwr_mode_e  pwr_q;

    sar_ctrl_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .din       (din),
        .start_ok  (start_ok),
        .cmd_done  (cmd_done),
        .short_req (short_req),
        .pwr_code  (pwr_code),
        .acq       (sampling),
        .pos       (mux_pos),
        .neg       (mux_neg),
        .neg_com   (neg_is_com)
    );

    sar_conv_core #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .load      (cmd_done),
        .res_sel   (res_sel),
        .short_req (short_req),
        .sample_in (sample_in),
        .active    (conv_active),
        .hold      (hold),
        .bit_valid (bit_valid),
        .bit_out   (bit_val),
        .start_ok  (start_ok)
    );

    sar_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .hold      (hold),
        .bit_valid (bit_valid),
        .bit_in    (bit_val),
        .busy      (busy),
        .dout      (dout)
    );

    // Power code of the most recent completed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= PWR_AUTO;
        end else if (cmd_done) begin
            pwr_q <= pwr_mode_e'(pwr_code);
        end
    end

    assign powered = shdn_n && (sampling || conv_active || (pwr_q == PWR_ON));
    assign dout_en = !cs_n;
    assign busy_en = !cs_n;
endmodule

// File: tb/sar_serial_adc_tb.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock model of the sequencer compared on every edge.
module sar_serial_adc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        res_sel = 1'b0;
    logic        shdn_n = 1'b1;
    logic [11:0] sample = '0;
    logic        dout, dout_en, busy, busy_en, sampling, neg_is_com, powered;
    logic [1:0]  mux_pos, mux_neg;

    int n_checks = 0;
    int n_err = 0;
    string ctx = "R11 reset";

    // model state
    int m_rx = 0, m_conv = -1, m_nb = 12, m_samp = 0, m_pos = 0, m_neg = 0, m_pd = 0;
    bit m_acq = 0, m_com = 0;
    logic [7:0] m_byte = '0;
    int e_busy = 0, e_dout = 0;

    always #2 clk = ~clk;

    sar_serial_adc u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .res_sel(res_sel),
        .shdn_n(shdn_n), .sample_in(sample), .dout(dout), .dout_en(dout_en),
        .busy(busy), .busy_en(busy_en), .sampling(sampling), .mux_pos(mux_pos),
        .mux_neg(mux_neg), .neg_is_com(neg_is_com), .powered(powered)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d at %0t", req, ctx, what, act, exp, $time);
        end
    endtask

    task automatic model_rise();
        bit ok;
        int old_rx;
        if (!rst_n) begin
            m_rx = 0; m_byte = '0; m_conv = -1; m_nb = 12; m_samp = 0;
            m_acq = 0; m_pos = 0; m_neg = 0; m_com = 0; m_pd = 0;
        end else if (cs_n) begin
            m_rx = 0; m_conv = -1; m_acq = 0;
        end else begin
            ok = (m_conv < 0) || (m_conv + 5 >= m_nb);
            old_rx = m_rx;
            if (m_conv >= 0) begin
                if (m_conv == m_nb) m_conv = -1;
                else m_conv++;
            end
            if (old_rx == 0) begin
                if (din && ok) begin m_rx = 1; m_byte = 8'h01; end
            end else begin
                m_byte = {m_byte[6:0], din};
                m_rx++;
                if (m_rx == 4) m_pos = {m_byte[1], m_byte[2]};
                if (m_rx == 5) m_acq = 1;
                if (m_rx == 6) begin m_com = din; m_neg = din ? 0 : (m_pos ^ 1); end
                if (m_rx == 8) begin
                    m_acq = 0; m_pd = m_byte[1:0];
                    m_nb = (res_sel && m_byte[3]) ? 8 : 12;
                    m_samp = sample; m_conv = 0; m_rx = 0;
                end
            end
        end
    endtask

    task automatic model_fall();
        e_busy = 0; e_dout = 0;
        if (rst_n && !cs_n) begin
            e_busy = (m_conv == 0) ? 1 : 0;
            if (m_conv >= 1) e_dout = ((m_samp >> (12 - m_nb)) >> (m_nb - m_conv)) & 1;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_rise();
        #1;
        check("R3", "sampling", int'(sampling), int'(m_acq));
        check("R2", "mux_pos", int'(mux_pos), m_pos);
        check("R2", "mux_neg", int'(mux_neg), m_neg);
        check("R2", "neg_is_com", int'(neg_is_com), int'(m_com));
        check("R10", "powered", int'(powered),
              (shdn_n && (m_acq || m_conv >= 0 || m_pd == 3)) ? 1 : 0);
        @(negedge clk);
        model_fall();
        #1;
        check("R4", "busy", int'(busy), e_busy);
        check((m_nb == 8) ? "R6" : "R5", "dout", int'(dout), e_dout);
        check("R8", "dout_en", int'(dout_en), int'(!cs_n));
        check("R8", "busy_en", int'(busy_en), int'(!cs_n));
    endtask

    function automatic logic [7:0] mk(logic [2:0] a, logic sz, logic sgl, logic [1:0] pd);
        return {1'b1, a, sz, sgl, pd};
    endfunction

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin din = b[i]; tick(); end
    endtask

    task automatic send_byte(logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic idle(int n);
        din = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic high(int n);
        din = 1'b1;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_checks++;
        $display("FAIL watchdog expired [%s]", ctx);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        ctx = "R11 reset";
        repeat (3) tick();
        rst_n = 1'b1;
        ctx = "R8 deselected";
        repeat (2) tick();
        cs_n = 1'b0;
        ctx = "R1 idle low input";
        idle(4);
        check("R1", "no window while idle", int'(sampling), 0);

        ctx = "R5 full resolution single-ended";
        sample = 12'hA5C;
        send_byte(mk(3'b101, 1'b0, 1'b1, 2'b11));
        idle(7);

        ctx = "R7 overlap into short conversion";
        res_sel = 1'b1; sample = 12'h3F7;
        send_byte(mk(3'b010, 1'b1, 1'b0, 2'b00));
        idle(3);
        ctx = "R6 short overlap all ones, reserved power code";
        sample = 12'hFFF;
        send_byte(mk(3'b110, 1'b1, 1'b0, 2'b01));
        idle(14);

        ctx = "R6 pin low forces 12 bits";
        res_sel = 1'b0; sample = 12'h001;
        send_byte(mk(3'b001, 1'b1, 1'b1, 2'b10));
        idle(7);

        ctx = "R7 early high bits ignored";
        sample = 12'h7FF;
        send_byte(mk(3'b101, 1'b0, 1'b0, 2'b11));
        high(7);
        sample = 12'hFFF;
        send_byte(mk(3'b010, 1'b0, 1'b1, 2'b00));
        idle(16);

        ctx = "R9 abort during conversion";
        sample = 12'h5A5;
        send_byte(mk(3'b001, 1'b0, 1'b1, 2'b11));
        idle(3);
        cs_n = 1'b1;
        tick();
        check("R9", "busy after abort", int'(busy), 0);
        check("R9", "dout after abort", int'(dout), 0);
        tick();
        cs_n = 1'b0;
        idle(2);
        ctx = "R9 abort mid command";
        send_bits(mk(3'b110, 1'b0, 1'b0, 2'b11), 5);
        cs_n = 1'b1; din = 1'b0;
        tick();
        check("R9", "window cleared", int'(sampling), 0);
        cs_n = 1'b0;
        idle(2);
        sample = 12'hC33;
        send_byte(mk(3'b010, 1'b0, 1'b0, 2'b00));
        idle(16);

        ctx = "R10 forced shutdown";
        shdn_n = 1'b0;
        idle(2);
        sample = 12'h800;
        send_byte(mk(3'b101, 1'b0, 1'b1, 2'b11));
        idle(14);
        shdn_n = 1'b1;
        idle(3);
        check("R10", "powered after code 11", int'(powered), 1);
        sample = 12'h0F0;
        send_byte(mk(3'b001, 1'b0, 1'b1, 2'b00));
        idle(16);
        check("R10", "powered down after code 00", int'(powered), 0);

        ctx = "R11 reset again";
        rst_n = 1'b0;
        idle(2);
        check("R11", "power code cleared", int'(powered), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule